// File: doc/BRIEF.md
# Input Glitch Filter with Scaled Hold Time

This block cleans up one general-purpose input pin. The raw pin passes through a two-flop synchroniser. A new level reaches the output only after the synchronised level has stayed different from the current output for a programmed hold time. That time is measured in ticks of a slow reference strobe. The reference strobe is a one-cycle pulse at about 32.768 kHz, generated outside the block.

The hold time is a 4-bit count multiplied by a unit. Two independent select bits choose one of four units: 2, 8, 512 or 2048 reference ticks. A mode field of zero bypasses the filter, and the synchronised level then goes straight to the output. A hold count of zero also removes the extra delay. If the synchronised level returns to the output level before the hold time ends, the hold measurement starts again from zero.

Top module: `pin_deglitch`

## Requirements
- R1: While `rst_n` is low, `pin_out` is 0 and any hold measurement in progress is discarded.
- R2: The raw pin goes through two synchroniser flops and one output flop. In bypass, a level driven on `pin_raw` before clock edge k therefore appears on `pin_out` after edge k+2.
- R3: When `filt_mode` is 0, the filter is bypassed: `pin_out` follows the synchronised level whatever the values of `ref_tick`, `hold_cnt` and the unit bits.
- R4: When `filt_mode` is nonzero and `hold_cnt` is 0, the output has the same latency as in bypass.
- R5: With `unit_long`=0 and `unit_coarse`=0, one count of `hold_cnt` equals 2 reference ticks.
- R6: With `unit_long`=0 and `unit_coarse`=1, one count equals 8 reference ticks.
- R7: With `unit_long`=1 and `unit_coarse`=0, one count equals 512 reference ticks.
- R8: With `unit_long`=1 and `unit_coarse`=1, one count equals 2048 reference ticks.
- R9: When filtering, the block counts only the ticks during which the synchronised level differs from `pin_out`. A return to the output level resets the count to zero, so a glitch shorter than the hold time never reaches the output.
- R10: When filtering with a nonzero count, `pin_out` changes only on the edge that samples the reference tick completing hold_cnt x unit differing ticks. If that target is lowered while a count is running, the next tick ends the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_raw | input | 1 | Unsynchronised pin level |
| ref_tick | input | 1 | One-cycle reference tick strobe |
| filt_mode | input | 2 | 0 = bypass; any other value = glitch removal |
| hold_cnt | input | 4 | Hold time in units |
| unit_coarse | input | 1 | Unit select, low bit |
| unit_long | input | 1 | Unit select, high bit |
| pin_out | output | 1 | Filtered level |

## Verification
In bypass, and with a zero hold count, `pin_out` is due three edges after `pin_raw` changes. When filtering, it is due one edge after the clock samples the tick that completes the hold time. A behavioural model in the bench tracks the same edges and is compared against `pin_out` at every falling clock edge. Directed checks sample just before and well after each computed change point, so a correct design is never caught in the middle of a transition.

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
  parameter int HOLD_W = 4,
  parameter int MODE_W = 2,
  parameter int SH_U0  = 1,
  parameter int SH_U1  = 3,
  parameter int SH_U2  = 9,
  parameter int SH_U3  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_raw,
  input  logic              ref_tick,
  input  logic [MODE_W-1:0] filt_mode,
  input  logic [HOLD_W-1:0] hold_cnt,
  input  logic              unit_coarse,
  input  logic              unit_long,
  output logic              pin_out
);
  localparam int TICK_W = HOLD_W + SH_U3;

  logic [1:0]        sync_q;
  logic [TICK_W-1:0] tick_cnt;
  logic [TICK_W-1:0] hold_ticks;
  logic [TICK_W:0]   next_cnt;

  wire sync_lvl  = sync_q[1];
  wire filter_on = (|filt_mode) && (|hold_cnt);
  wire differs   = sync_lvl != pin_out;
  wire done      = next_cnt >= {1'b0, hold_ticks};

  assign next_cnt = {1'b0, tick_cnt} + 1'b1;

  always_comb begin
    case ({unit_long, unit_coarse})
      2'b00:   hold_ticks = TICK_W'(hold_cnt) << SH_U0;
      2'b01:   hold_ticks = TICK_W'(hold_cnt) << SH_U1;
      2'b10:   hold_ticks = TICK_W'(hold_cnt) << SH_U2;
      default: hold_ticks = TICK_W'(hold_cnt) << SH_U3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      pin_out  <= 1'b0;
      tick_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_raw};
      if (!filter_on) begin
        pin_out  <= sync_lvl;
        tick_cnt <= '0;
      end else if (!differs) begin
        tick_cnt <= '0;
      end else if (ref_tick) begin
        if (done) begin
          pin_out  <= sync_lvl;
          tick_cnt <= '0;
        end else begin
          tick_cnt <= next_cnt[TICK_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/pin_deglitch_chk.sv
module pin_deglitch_chk #(
  parameter int HOLD_W = 4,
  parameter int MODE_W = 2,
  parameter int TW     = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pin_raw,
  input logic              ref_tick,
  input logic [MODE_W-1:0] filt_mode,
  input logic [HOLD_W-1:0] hold_cnt,
  input logic              pin_out,
  input logic              sync_lvl,
  input logic [TW-1:0]     tick_cnt
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_low_r1: assert (pin_out == 1'b0 && tick_cnt == '0)
        else $error("pin_out or tick count not cleared in reset");
    end
  end

  p_bypass_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(filt_mode) == '0) |-> pin_out == $past(pin_raw, 3));

  p_bypass_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(filt_mode) == '0) |-> pin_out == $past(sync_lvl));

  p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_mode != '0 && hold_cnt == '0) |=> pin_out == $past(sync_lvl));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl == pin_out) |=> tick_cnt == '0);

  p_tick_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(filt_mode) != '0 && $past(hold_cnt) != '0 && !$past(ref_tick))
      |-> $stable(pin_out));
endmodule

bind pin_deglitch pin_deglitch_chk #(.HOLD_W(HOLD_W), .MODE_W(MODE_W), .TW(TICK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .ref_tick(ref_tick),
  .filt_mode(filt_mode), .hold_cnt(hold_cnt), .pin_out(pin_out),
  .sync_lvl(sync_lvl), .tick_cnt(tick_cnt)
);

// File: tb/pin_deglitch_tb_top.sv
module pin_deglitch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic       ref_tick = 1'b0;
  logic [1:0] filt_mode = 2'd0;
  logic [3:0] hold_cnt = 4'd0;
  logic       unit_coarse = 1'b0;
  logic       unit_long = 1'b0;
  logic       pin_out;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    tick_en = 1'b0;
  bit    done_flag = 1'b0;
  int    tick_div = 0;

  always #2 clk = ~clk;

  pin_deglitch dut_i (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .ref_tick(ref_tick),
    .filt_mode(filt_mode), .hold_cnt(hold_cnt), .unit_coarse(unit_coarse),
    .unit_long(unit_long), .pin_out(pin_out)
  );

  // reference strobe: one cycle high out of every three
  always @(negedge clk) begin
    tick_div = (tick_div == 2) ? 0 : tick_div + 1;
    ref_tick <= tick_en && (tick_div == 0);
  end

  function automatic int unit_ticks(bit lg, bit cs);
    if (!lg && !cs) return 2;
    if (!lg && cs)  return 8;
    if (lg && !cs)  return 512;
    return 2048;
  endfunction

  // behavioural reference model
  bit m_a, m_b, m_q;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_q = 0; m_cnt = 0;
    end else begin
      int target;
      target = int'(hold_cnt) * unit_ticks(unit_long, unit_coarse);
      if (filt_mode == 2'd0 || hold_cnt == 4'd0) begin
        m_q = m_b; m_cnt = 0;
      end else if (m_b == m_q) begin
        m_cnt = 0;
      end else if (ref_tick) begin
        if (m_cnt + 1 >= target) begin m_q = m_b; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      m_b = m_a;
      m_a = pin_raw;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      checks++;
      if (pin_out !== m_q) begin
        errors++;
        $display("FAIL %s model compare actual=%0b expected=%0b t=%0t", cur_req, pin_out, m_q, $time);
      end
    end
  end

  task automatic chk(string req, bit exp);
    checks++;
    if (pin_out !== exp) begin
      errors++;
      $display("FAIL %s directed actual=%0b expected=%0b t=%0t", req, pin_out, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(string req, bit [1:0] md, bit [3:0] h, bit lg, bit cs);
    @(negedge clk);
    cur_req = req; filt_mode = md; hold_cnt = h; unit_long = lg; unit_coarse = cs;
  endtask

  task automatic timed_edge(string req, bit lvl, int target_ticks);
    @(negedge clk);
    pin_raw = lvl;
    wait_n(3 * target_ticks - 6);
    chk(req, ~lvl);
    wait_n(12);
    chk(req, lvl);
  endtask

  initial begin
    wait_n(4);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1", 1'b0);

    // bypass, no ticks
    setup("R2", 2'd0, 4'd5, 1'b1, 1'b1);
    pin_raw = 1'b1;
    wait_n(2); chk("R2", 1'b0);
    wait_n(1); chk("R2", 1'b1);
    cur_req = "R3";
    @(negedge clk); pin_raw = 1'b0;
    wait_n(3); chk("R3", 1'b0);

    // zero hold count, filtering selected
    setup("R4", 2'd1, 4'd0, 1'b0, 1'b0);
    pin_raw = 1'b1;
    wait_n(2); chk("R4", 1'b0);
    wait_n(1); chk("R4", 1'b1);

    tick_en = 1'b1;
    setup("R5", 2'd1, 4'd3, 1'b0, 1'b0);
    timed_edge("R5", 1'b0, 6);

    // glitch shorter than the hold time
    setup("R9", 2'd2, 4'd3, 1'b0, 1'b0);
    pin_raw = 1'b1; wait_n(12);
    pin_raw = 1'b0; wait_n(3);
    pin_raw = 1'b1; wait_n(12);
    chk("R9", 1'b0);
    pin_raw = 1'b0; wait_n(30);
    chk("R9", 1'b0);

    setup("R6", 2'd3, 4'd2, 1'b0, 1'b1);
    timed_edge("R6", 1'b1, 16);

    // lower target mid-count
    setup("R10", 2'd1, 4'd15, 1'b0, 1'b1);
    pin_raw = 1'b0; wait_n(60);
    chk("R10", 1'b1);
    hold_cnt = 4'd1; wait_n(8);
    chk("R10", 1'b0);

    setup("R7", 2'd1, 4'd1, 1'b1, 1'b0);
    timed_edge("R7", 1'b1, 512);

    setup("R8", 2'd1, 4'd2, 1'b1, 1'b1);
    timed_edge("R8", 1'b0, 4096);

    wait_n(4);
    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done_flag = 1'b1;
    checks++;
    errors++;
    $display("FAIL %s watchdog expired actual=running expected=finished", cur_req);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule